// File: doc/BRIEF.md
# Direct-Access Eligibility Gate

This block decides, for each physical address a CPU presents, whether the access may go straight to backing memory or must be refused and sent down the slow, handled path. The verdict depends on four things: the page of the local interrupt controller, a page watched by per-CPU monitor flags, a table of ranges claimed by memory-mapped devices, and the state of the system-management RAM window. Instruction fetches are judged apart from data reads and from writes.

Queries enter on a valid/ready channel and leave one cycle later on a second valid/ready channel. `q_ready` is high whenever the result slot is empty or being drained (`!r_valid || r_ready`). While `r_valid` is high and `r_ready` is low, the result stays frozen and no new query is taken. Configuration pins (range writes, monitor set and clear, interrupt-controller page, SMRAM on and off) are plain single-cycle strobes. A query accepted in the same cycle as a strobe is judged against the state that held before that strobe.

Top module: `fastpath_gate`

## Requirements
- R1: A query whose address bits [31:12] equal the interrupt-controller page register is refused, whatever its operation or type. That register resets to 0xFEE00 and is loaded by `apic_we`.
- R2: An instruction fetch (`q_code`=1) with an address in 0xA0000–0xBFFFF is allowed when SMRAM is available and either SMRAM is enabled or `q_smm`=1. This outranks R3, R4 and R8.
- R3: When the monitor count is non-zero and address bits [31:12] equal the watched page, a write (`q_op`=01), a read-modify-write (`q_op`=10) or code 11 (treated as a write) is refused. A read (`q_op`=00) is not affected.
- R4: An address within any valid range entry, with both bounds inclusive, is refused. This holds for ranges that cross 1 MiB boundaries.
- R5: A registration (`rng_we`=1, `rng_add`=1) with `rng_hi` < `rng_lo` is rejected and leaves the entry unchanged. A removal (`rng_add`=0) invalidates the entry.
- R6: `smram_data_ok` = available AND (enabled OR NOT restricted).
- R7: A non-read access is refused when the address is at or above the memory size (default 0x0200_0000), in 0xA0000–0xBFFFF, in 0xC0000–0xFFFFF, or in the top 128 KiB of the address space. Any other non-read access is allowed.
- R8: A read in 0xA0000–0xBFFFF is refused. All other reads that no earlier rule refuses are allowed, including ROM areas and addresses beyond the memory size.
- R9: `smram_on` sets available=1 and loads the enable and restrict bits. `smram_off` clears all three bits and wins when both strobes are high.
- R10: The monitor count equals the number of set CPU flags. Setting a flag that is already set, or clearing one that is clear, leaves the count unchanged. `mon_clr` wins over `mon_set`.
- R11: `q_ready` = `!r_valid || r_ready`. A stalled result keeps its value. A query is judged on the state that held before any strobe in the same cycle.
- R12: After reset, `r_valid`=0, `smram_data_ok`=0, no range is valid and the monitor count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_valid | input | 1 | Query present |
| q_ready | output | 1 | Query taken this cycle |
| q_addr | input | 32 | Physical address |
| q_op | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 treated as write |
| q_code | input | 1 | Instruction fetch |
| q_smm | input | 1 | CPU is in system-management mode |
| r_valid | output | 1 | Verdict present |
| r_ready | input | 1 | Consumer takes the verdict |
| r_allow | output | 1 | 1 = direct path allowed, 0 = refused |
| smram_data_ok | output | 1 | SMRAM open to data accesses |
| smram_on | input | 1 | Strobe: make SMRAM available |
| smram_on_enable | input | 1 | Enable bit loaded by `smram_on` |
| smram_on_restrict | input | 1 | Restrict bit loaded by `smram_on` |
| smram_off | input | 1 | Strobe: clear all SMRAM bits |
| apic_we | input | 1 | Load the interrupt-controller page |
| apic_page | input | 20 | New interrupt-controller page |
| mon_set | input | 1 | Set the flag of `mon_cpu` |
| mon_clr | input | 1 | Clear the flag of `mon_cpu` |
| mon_cpu | input | 2 | CPU index for the flag strobes |
| mon_page_we | input | 1 | Load the watched page |
| mon_page | input | 20 | New watched page |
| rng_we | input | 1 | Range table write |
| rng_add | input | 1 | 1 = register, 0 = remove |
| rng_idx | input | 3 | Table entry |
| rng_lo | input | 32 | Inclusive lower bound |
| rng_hi | input | 32 | Inclusive upper bound |

## Verification
The assertions assume that `q_op`, `q_code` and `q_addr` hold steady while `q_valid` waits for `q_ready`, and that `mon_cpu` and `rng_idx` name existing entries. The bench drives each query until the handshake completes. It uses only CPU indices 0–3 and entries 0–7, and it raises `smram_on` and `smram_off` in separate cycles except where R9's priority is the subject of the test. Same-cycle strobe and query collisions are created on purpose, and back-pressure is applied by holding `r_ready` low across a queued query.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'b00,
    OP_WR  = 2'b01,
    OP_RMW = 2'b10,
    OP_RSV = 2'b11
  } op_e;

  typedef struct packed {
    logic avail;
    logic en;
    logic restr;
  } smram_t;
endpackage

// File: rtl/fpg_range_table.sv
module fpg_range_table #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_add,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_lo,
  input  logic [ADDR_W-1:0] wr_hi,
  input  logic [ADDR_W-1:0] probe,
  output logic              hit
);
  logic [ENTRIES-1:0] vld_q;
  logic [ADDR_W-1:0]  lo_q [ENTRIES];
  logic [ADDR_W-1:0]  hi_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign hit_vec[i] = vld_q[i] && (probe >= lo_q[i]) && (probe <= hi_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
      end else if (wr_en && (int'(wr_idx) == i)) begin
        if (!wr_add) begin
          vld_q[i] <= 1'b0;
        end else if (wr_hi >= wr_lo) begin
          vld_q[i] <= 1'b1;
          lo_q[i]  <= wr_lo;
          hi_q[i]  <= wr_hi;
        end
      end
    end
  end

  assign hit = |hit_vec;

  // R5
  bad_range_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_add && (wr_hi < wr_lo)) |=> $stable(vld_q));
endmodule

// File: rtl/fpg_monitor.sv
module fpg_monitor #(
  parameter int CPUS   = 4,
  parameter int PAGE_W = 20,
  localparam int CPU_W = (CPUS > 1) ? $clog2(CPUS) : 1,
  localparam int CNT_W = $clog2(CPUS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic              clr,
  input  logic [CPU_W-1:0]  cpu,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_in,
  input  logic [PAGE_W-1:0] probe_page,
  output logic              watch_hit
);
  logic [CPUS-1:0]   flag_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      cnt_q  <= '0;
      page_q <= '0;
    end else begin
      if (page_we) page_q <= page_in;
      if (clr && flag_q[cpu]) begin
        flag_q[cpu] <= 1'b0;
        cnt_q       <= cnt_q - 1'b1;
      end else if (set && !clr && !flag_q[cpu]) begin
        flag_q[cpu] <= 1'b1;
        cnt_q       <= cnt_q + 1'b1;
      end
    end
  end

  assign watch_hit = (cnt_q != '0) && (page_q == probe_page);

  // R10
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) == $countones(flag_q));
endmodule

// File: rtl/fpg_veto.sv
module fpg_veto
  import fpg_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter longint      MEM_BYTES = 64'h0200_0000,
  parameter int          ROM_LOG2  = 17,
  localparam int         PAGE_W    = ADDR_W - 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  op_e               op,
  input  logic              code,
  input  logic              smm,
  input  logic [PAGE_W-1:0] apic_page,
  input  smram_t            smram,
  input  logic              watch_hit,
  input  logic              range_hit,
  output logic              allow
);
  localparam logic [ADDR_W:0] MEM_LIM = (ADDR_W+1)'(MEM_BYTES);

  logic in_video, in_exp, in_rom_top, past_mem, is_read, smram_code;

  always_comb begin
    in_video   = (addr[ADDR_W-1:17] == (ADDR_W-17)'(5));
    in_exp     = (addr[ADDR_W-1:18] == (ADDR_W-18)'(3));
    in_rom_top = &addr[ADDR_W-1:ROM_LOG2];
    past_mem   = ({1'b0, addr} >= MEM_LIM);
    is_read    = (op == OP_RD);
    smram_code = code && in_video && smram.avail && (smram.en || smm);

    if (addr[ADDR_W-1:12] == apic_page)       allow = 1'b0;
    else if (smram_code)                      allow = 1'b1;
    else if (watch_hit && !is_read)           allow = 1'b0;
    else if (range_hit)                       allow = 1'b0;
    else if (is_read)                         allow = !in_video;
    else allow = !(past_mem || in_video || in_rom_top || in_exp);
  end
endmodule

// File: rtl/fastpath_gate.sv
module fastpath_gate
  import fpg_pkg::*;
#(
  parameter int     ADDR_W     = 32,
  parameter int     ENTRIES    = 8,
  parameter int     CPUS       = 4,
  parameter longint MEM_BYTES  = 64'h0200_0000,
  parameter int     ROM_LOG2   = 17,
  parameter int     APIC_RESET = 32'h000F_EE00,
  localparam int    PAGE_W     = ADDR_W - 12,
  localparam int    IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int    CPU_W      = (CPUS > 1) ? $clog2(CPUS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_valid,
  output logic              q_ready,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [1:0]        q_op,
  input  logic              q_code,
  input  logic              q_smm,
  output logic              r_valid,
  input  logic              r_ready,
  output logic              r_allow,
  output logic              smram_data_ok,
  input  logic              smram_on,
  input  logic              smram_on_enable,
  input  logic              smram_on_restrict,
  input  logic              smram_off,
  input  logic              apic_we,
  input  logic [PAGE_W-1:0] apic_page,
  input  logic              mon_set,
  input  logic              mon_clr,
  input  logic [CPU_W-1:0]  mon_cpu,
  input  logic              mon_page_we,
  input  logic [PAGE_W-1:0] mon_page,
  input  logic              rng_we,
  input  logic              rng_add,
  input  logic [IDX_W-1:0]  rng_idx,
  input  logic [ADDR_W-1:0] rng_lo,
  input  logic [ADDR_W-1:0] rng_hi
);
  localparam logic [ADDR_W:0] MEM_LIM = (ADDR_W+1)'(MEM_BYTES);

  logic [PAGE_W-1:0] apic_q;
  smram_t            smram_q;
  logic              rv_q, ra_q, accept, range_hit, watch_hit, allow_d;

  fpg_range_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_ranges (
    .clk, .rst_n, .wr_en(rng_we), .wr_add(rng_add), .wr_idx(rng_idx),
    .wr_lo(rng_lo), .wr_hi(rng_hi), .probe(q_addr), .hit(range_hit));

  fpg_monitor #(.CPUS(CPUS), .PAGE_W(PAGE_W)) u_mon (
    .clk, .rst_n, .set(mon_set), .clr(mon_clr), .cpu(mon_cpu),
    .page_we(mon_page_we), .page_in(mon_page),
    .probe_page(q_addr[ADDR_W-1:12]), .watch_hit(watch_hit));

  fpg_veto #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .ROM_LOG2(ROM_LOG2)) u_veto (
    .addr(q_addr), .op(op_e'(q_op)), .code(q_code), .smm(q_smm),
    .apic_page(apic_q), .smram(smram_q), .watch_hit(watch_hit),
    .range_hit(range_hit), .allow(allow_d));

  assign q_ready       = !rv_q || r_ready;
  assign accept        = q_valid && q_ready;
  assign r_valid       = rv_q;
  assign r_allow       = ra_q;
  assign smram_data_ok = smram_q.avail && (smram_q.en || !smram_q.restr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q    <= 1'b0;
      ra_q    <= 1'b0;
      apic_q  <= PAGE_W'(APIC_RESET);
      smram_q <= '0;
    end else begin
      if (accept) begin
        rv_q <= 1'b1;
        ra_q <= allow_d;
      end else if (r_ready) begin
        rv_q <= 1'b0;
      end
      if (apic_we) apic_q <= apic_page;
      if (smram_off)     smram_q <= '0;
      else if (smram_on) smram_q <= '{avail: 1'b1, en: smram_on_enable, restr: smram_on_restrict};
    end
  end

  // R1
  apic_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (q_addr[ADDR_W-1:12] == apic_q)) |=> (r_valid && !r_allow));
  // R7
  write_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (q_op != 2'b00) && !q_code && ({1'b0, q_addr} >= MEM_LIM)) |=> !r_allow);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_allow)));
  // R9
  smram_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smram_off |=> !smram_data_ok);
endmodule

// File: tb/test_fastpath_gate.sv
module test_fastpath_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic q_valid = 0, q_code = 0, q_smm = 0, r_ready = 1;
  logic [31:0] q_addr = 0, rng_lo = 0, rng_hi = 0;
  logic [1:0] q_op = 0, mon_cpu = 0;
  logic smram_on = 0, smram_on_enable = 0, smram_on_restrict = 0, smram_off = 0;
  logic apic_we = 0, mon_set = 0, mon_clr = 0, mon_page_we = 0, rng_we = 0, rng_add = 0;
  logic [19:0] apic_page = 0, mon_page = 0;
  logic [2:0] rng_idx = 0;
  logic q_ready, r_valid, r_allow, smram_data_ok;

  int checks = 0, failures = 0;
  string cur_req = "R12";
  bit done = 0;

  // behavioural reference state
  bit m_vld[8]; logic [31:0] m_lo[8], m_hi[8];
  bit m_flag[4]; int m_cnt; logic [19:0] m_mpage, m_apic;
  bit m_av, m_en, m_rs, mv, ma;

  always #4 clk = ~clk;

  fastpath_gate i_fastpath_gate (.*);

  function automatic bit decide(logic [31:0] a, logic [1:0] op, bit code, bit smm);
    bit video = (a >= 32'hA0000 && a < 32'hC0000);
    if (a[31:12] == m_apic) return 0;
    if (code && video && m_av && (m_en || smm)) return 1;
    if (m_cnt > 0 && a[31:12] == m_mpage && op != 2'b00) return 0;
    for (int i = 0; i < 8; i++) if (m_vld[i] && a >= m_lo[i] && a <= m_hi[i]) return 0;
    if (op == 2'b00) return !video;
    if (a >= 32'h0200_0000 || video || a >= 32'hFFFE_0000) return 0;
    if (a >= 32'hC0000 && a <= 32'hFFFFF) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_vld[i] = 0;
      for (int i = 0; i < 4; i++) m_flag[i] = 0;
      m_cnt = 0; m_mpage = 0; m_apic = 20'hFEE00;
      m_av = 0; m_en = 0; m_rs = 0; mv = 0; ma = 0;
    end else begin
      if (q_valid && (!mv || r_ready)) begin
        mv = 1; ma = decide(q_addr, q_op, q_code, q_smm);
      end else if (r_ready) mv = 0;
      if (rng_we) begin
        if (!rng_add) m_vld[rng_idx] = 0;
        else if (rng_hi >= rng_lo) begin
          m_vld[rng_idx] = 1; m_lo[rng_idx] = rng_lo; m_hi[rng_idx] = rng_hi;
        end
      end
      if (mon_page_we) m_mpage = mon_page;
      if (mon_clr) begin
        if (m_flag[mon_cpu]) begin m_flag[mon_cpu] = 0; m_cnt--; end
      end else if (mon_set && !m_flag[mon_cpu]) begin
        m_flag[mon_cpu] = 1; m_cnt++;
      end
      if (apic_we) m_apic = apic_page;
      if (smram_off) begin m_av = 0; m_en = 0; m_rs = 0; end
      else if (smram_on) begin m_av = 1; m_en = smram_on_enable; m_rs = smram_on_restrict; end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("r_valid", 32'(r_valid), 32'(mv));
      chk("q_ready", 32'(q_ready), 32'(!mv || r_ready));
      chk("smram_data_ok", 32'(smram_data_ok), 32'(m_av && (m_en || !m_rs)));
      if (mv) chk("r_allow", 32'(r_allow), 32'(ma));
    end
  end

  task automatic query(logic [31:0] a, logic [1:0] op, bit code = 0, bit smm = 0);
    bit acc;
    @(negedge clk);
    q_valid = 1; q_addr = a; q_op = op; q_code = code; q_smm = smm;
    do begin #1; acc = q_ready; @(negedge clk); end while (!acc);
    q_valid = 0;
  endtask

  task automatic strobe_smram(bit on, bit en, bit rs, bit off);
    @(negedge clk);
    smram_on = on; smram_on_enable = en; smram_on_restrict = rs; smram_off = off;
    @(negedge clk); smram_on = 0; smram_off = 0;
  endtask

  task automatic mon(bit s, bit c, logic [1:0] cpu);
    @(negedge clk); mon_set = s; mon_clr = c; mon_cpu = cpu;
    @(negedge clk); mon_set = 0; mon_clr = 0;
  endtask

  task automatic rng(bit add, logic [2:0] idx, logic [31:0] lo, logic [31:0] hi);
    @(negedge clk); rng_we = 1; rng_add = add; rng_idx = idx; rng_lo = lo; rng_hi = hi;
    @(negedge clk); rng_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R12";
    @(negedge clk); #1;
    chk("reset r_valid", 32'(r_valid), 0);
    chk("reset smram_data_ok", 32'(smram_data_ok), 0);
    query(32'h0040_0000, 2'b01);            // no range valid, no monitor

    cur_req = "R8";
    query(32'h0000_1000, 2'b00); query(32'h000A_0000, 2'b00); query(32'h000B_FFFF, 2'b00);
    query(32'h000C_8000, 2'b00); query(32'hFFFF_0000, 2'b00); query(32'h3000_0000, 2'b00);

    cur_req = "R7";
    query(32'h0000_1000, 2'b01); query(32'h000A_0000, 2'b01); query(32'h000D_0000, 2'b10);
    query(32'h000F_FFFF, 2'b01); query(32'hFFFF_0000, 2'b01); query(32'h0200_0000, 2'b01);
    query(32'h01FF_FFFF, 2'b10); query(32'h0009_FFFF, 2'b11); query(32'h0010_0000, 2'b01);

    cur_req = "R1";
    query(32'hFEE0_0010, 2'b00);
    @(negedge clk); apic_we = 1; apic_page = 20'h00005; @(negedge clk); apic_we = 0;
    query(32'h0000_5008, 2'b00); query(32'h0000_6000, 2'b01); query(32'hFEE0_0010, 2'b00);

    cur_req = "R2";
    query(32'h000A_1000, 2'b00, 1, 1);
    strobe_smram(1, 0, 1, 0);
    cur_req = "R6"; @(negedge clk);
    cur_req = "R2";
    query(32'h000A_1000, 2'b00, 1, 0); query(32'h000A_1000, 2'b00, 1, 1);
    query(32'h000A_1000, 2'b00, 0, 1);
    strobe_smram(1, 1, 1, 0);
    query(32'h000B_0000, 2'b00, 1, 0);
    cur_req = "R6"; strobe_smram(1, 0, 0, 0); @(negedge clk);
    cur_req = "R9"; strobe_smram(1, 1, 0, 1);
    query(32'h000A_1000, 2'b00, 1, 1);
    strobe_smram(0, 0, 0, 1);

    cur_req = "R3";
    @(negedge clk); mon_page_we = 1; mon_page = 20'h00020; @(negedge clk); mon_page_we = 0;
    query(32'h0002_0004, 2'b01);
    mon(1, 0, 1);
    query(32'h0002_0004, 2'b01); query(32'h0002_0004, 2'b00); query(32'h0002_0FFF, 2'b10);
    query(32'h0002_1000, 2'b01);
    cur_req = "R10";
    mon(1, 0, 1); mon(0, 1, 1);
    query(32'h0002_0004, 2'b01);
    mon(0, 1, 2); query(32'h0002_0004, 2'b01);
    mon(1, 0, 0); mon(1, 0, 3); mon(0, 1, 0);
    query(32'h0002_0004, 2'b01);
    mon(1, 1, 2); query(32'h0002_0004, 2'b01);
    mon(0, 1, 3); query(32'h0002_0004, 2'b01);

    cur_req = "R4";
    rng(1, 0, 32'h0004_0000, 32'h0004_FFFF);
    query(32'h0004_0000, 2'b00); query(32'h0004_FFFF, 2'b01);
    query(32'h0005_0000, 2'b00); query(32'h0003_FFFF, 2'b00);
    rng(1, 7, 32'h00F0_0000, 32'h0110_0000);
    query(32'h0100_0000, 2'b00); query(32'h0110_0001, 2'b00);
    rng(0, 0, 0, 0);
    query(32'h0004_0000, 2'b00);

    cur_req = "R5";
    rng(1, 7, 32'h0000_2000, 32'h0000_1000);
    query(32'h0100_0000, 2'b00); query(32'h0000_1800, 2'b00);
    rng(1, 1, 32'h0000_7000, 32'h0000_7000);
    query(32'h0000_7000, 2'b00); query(32'h0000_7001, 2'b00);

    cur_req = "R11";
    @(negedge clk);
    rng_we = 1; rng_add = 1; rng_idx = 2; rng_lo = 32'h8000; rng_hi = 32'h8FFF;
    q_valid = 1; q_addr = 32'h8000; q_op = 2'b01; q_code = 0; q_smm = 0;
    @(negedge clk); rng_we = 0; q_valid = 0;
    query(32'h0000_8000, 2'b01);
    @(negedge clk); r_ready = 0;
    query(32'h0000_8000, 2'b00);
    fork
      query(32'h0000_9000, 2'b00);
      begin repeat (5) @(negedge clk); r_ready = 1; end
    join
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule